// File: doc/BRIEF.md
# Two-Level Masked Interrupt Status Unit

This block gathers four single-cycle event pulses from a serial flash controller: chip-select released, write buffer ready, read buffer ready and transfer done. Each pulse is recorded in a sticky status register, but only when its bit in a status-enable mask is set. A second mask, the signal-enable mask, decides which recorded bits drive the single interrupt line. Because the two masks are separate, software can poll a recorded bit while the interrupt line stays quiet.

Software reaches the three registers through a plain register port with a combinational read. It clears recorded bits by writing ones to them. A typical flow enables transfer-done in the status-enable mask and starts a transfer. It then polls the status register until bit 0 is set, and writes that same bit back to clear it.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status register, both masks and the interrupt output are all zero.
- R2: A pulse on an event input whose status-enable bit is set makes the matching status bit read as one from the next clock edge onward, and the bit stays set after the pulse ends. The bit positions are: chip-select released is bit 8, write buffer ready is bit 2, read buffer ready is bit 1, and transfer done is bit 0.
- R3: A pulse on an event input whose status-enable bit is clear leaves its status bit at zero.
- R4: A write to the status register at byte address 0x0 clears every bit written as one and leaves every bit written as zero unchanged.
- R5: If an enabled event pulse arrives in the same cycle as a write that clears its bit, the bit stays set.
- R6: The interrupt output is high exactly when some bit is set in both the status register and the signal-enable mask. A status bit that is set while its signal-enable bit is clear keeps the output low.
- R7: The status-enable mask at byte address 0x4 and the signal-enable mask at byte address 0x8 read back what was written, limited to bits 8, 2, 1 and 0. All other bit positions read as zero and ignore writes. Any other address reads as zero.
- R8: Clearing a status-enable bit does not clear a status bit that is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_cs_release | input | 1 | Chip-select released event pulse |
| ev_wbuf_ready | input | 1 | Write buffer ready event pulse |
| ev_rbuf_ready | input | 1 | Read buffer ready event pulse |
| ev_xfer_done | input | 1 | Transfer done event pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| irq | output | 1 | Interrupt output |

## Verification
The bench uses the default widths: a 32-bit data word and a 4-bit byte address. With these widths, writes of all ones reach the unused bit positions above bit 8, and the spare address 0xC can be read. Under these widths the bench checks that a clear write and an event in the same cycle leave the bit set. It also checks that a bit can be polled while its interrupt is masked, and that a bit stays set after its status-enable bit is removed.

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_cs_release,
  input  logic              ev_wbuf_ready,
  input  logic              ev_rbuf_ready,
  input  logic              ev_xfer_done,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int POS_CS   = 8;
  localparam int POS_WBUF = 2;
  localparam int POS_RBUF = 1;
  localparam int POS_DONE = 0;
  localparam logic [DATA_W-1:0] LIVE =
    (DATA_W'(1) << POS_CS) | (DATA_W'(1) << POS_WBUF) |
    (DATA_W'(1) << POS_RBUF) | (DATA_W'(1) << POS_DONE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STEN = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SGEN = ADDR_W'(8);

  logic [DATA_W-1:0] ev_w;
  logic [DATA_W-1:0] status_q, sten_q, sgen_q;
  logic [DATA_W-1:0] clr_w;

  always_comb begin
    ev_w = '0;
    ev_w[POS_CS]   = ev_cs_release;
    ev_w[POS_WBUF] = ev_wbuf_ready;
    ev_w[POS_RBUF] = ev_rbuf_ready;
    ev_w[POS_DONE] = ev_xfer_done;
  end

  assign clr_w = (reg_wr && reg_addr == A_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      sten_q   <= '0;
      sgen_q   <= '0;
    end else begin
      status_q <= ((status_q & ~clr_w) | (ev_w & sten_q)) & LIVE;
      if (reg_wr && reg_addr == A_STEN) sten_q <= reg_wdata & LIVE;
      if (reg_wr && reg_addr == A_SGEN) sgen_q <= reg_wdata & LIVE;
    end
  end

  always_comb begin
    case (reg_addr)
      A_STAT:  reg_rdata = status_q;
      A_STEN:  reg_rdata = sten_q;
      A_SGEN:  reg_rdata = sgen_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(status_q & sgen_q);
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] ev_w,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] sten_q,
  input logic [DATA_W-1:0] sgen_q,
  input logic              irq
);
  localparam logic [DATA_W-1:0] LIVE =
    (DATA_W'(1) << 8) | (DATA_W'(1) << 2) | (DATA_W'(1) << 1) | DATA_W'(1);

  for (genvar k = 0; k < DATA_W; k++) begin : g_bit
    if (LIVE[k]) begin : g_live
      a_r2_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_w[k] && sten_q[k]) |=> status_q[k]);
      a_r3_no_latch_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (!status_q[k] && !(ev_w[k] && sten_q[k])) |=> !status_q[k]);
      a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == '0 && reg_wdata[k] && !ev_w[k]) |=> !status_q[k]);
      a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[k] && !(reg_wr && reg_addr == '0 && reg_wdata[k])) |=> status_q[k]);
    end else begin : g_dead
      a_r7_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status_q[k] && !sten_q[k] && !sgen_q[k]);
    end
  end

  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & sgen_q) == '0) |-> !irq);
endmodule

bind irq_status_unit irq_status_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_w(ev_w), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .status_q(status_q), .sten_q(sten_q), .sgen_q(sgen_q),
  .irq(irq)
);

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [DW-1:0] LIVE = 32'h0000_0107;

  logic clk = 0, rst_n = 0;
  logic ev_cs = 0, ev_wb = 0, ev_rb = 0, ev_dn = 0;
  logic wr = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata;
  logic irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_status_unit #(.ADDR_W(AW), .DATA_W(DW)) i_irq_status_unit (
    .clk(clk), .rst_n(rst_n), .ev_cs_release(ev_cs), .ev_wbuf_ready(ev_wb),
    .ev_rbuf_ready(ev_rb), .ev_xfer_done(ev_dn), .reg_wr(wr), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq(irq));

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_reg(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse(logic [3:0] v);
    @(negedge clk); {ev_cs, ev_wb, ev_rb, ev_dn} = v;
    @(negedge clk); {ev_cs, ev_wb, ev_rb, ev_dn} = '0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    rd_reg(4'h0, d); chk("R1 status", d, 0);
    rd_reg(4'h4, d); chk("R1 sten", d, 0);
    rd_reg(4'h8, d); chk("R1 sgen", d, 0);
    chk("R1 irq", DW'(irq), 0);
  endtask

  task automatic t_latch;
    logic [DW-1:0] d;
    wr_reg(4'h4, LIVE);
    pulse(4'b0001); rd_reg(4'h0, d); chk("R2 done bit0", d, 32'h001);
    pulse(4'b0010); rd_reg(4'h0, d); chk("R2 rbuf bit1", d, 32'h003);
    pulse(4'b0100); rd_reg(4'h0, d); chk("R2 wbuf bit2", d, 32'h007);
    pulse(4'b1000); rd_reg(4'h0, d); chk("R2 cs bit8", d, 32'h107);
    repeat (3) @(negedge clk);
    rd_reg(4'h0, d); chk("R2 sticky", d, 32'h107);
    chk("R6 polled but masked", DW'(irq), 0);
    wr_reg(4'h0, LIVE);
  endtask

  task automatic t_masked;
    logic [DW-1:0] d;
    wr_reg(4'h4, 32'h001);
    pulse(4'b1110); rd_reg(4'h0, d); chk("R3 masked events", d, 0);
    pulse(4'b0001); rd_reg(4'h0, d); chk("R3 enabled event", d, 32'h001);
    wr_reg(4'h0, 32'h001);
  endtask

  task automatic t_clear;
    logic [DW-1:0] d;
    wr_reg(4'h4, LIVE);
    pulse(4'b1111);
    wr_reg(4'h0, 32'h0); rd_reg(4'h0, d); chk("R4 zero write", d, 32'h107);
    wr_reg(4'h0, 32'h2); rd_reg(4'h0, d); chk("R4 clear bit1", d, 32'h105);
    wr_reg(4'h0, 32'h100); rd_reg(4'h0, d); chk("R4 clear bit8", d, 32'h005);
    wr_reg(4'h0, LIVE); rd_reg(4'h0, d); chk("R4 clear all", d, 0);
  endtask

  task automatic t_race;
    logic [DW-1:0] d;
    pulse(4'b0001);
    @(negedge clk); wr = 1; addr = 4'h0; wdata = 32'h1; ev_dn = 1;
    @(negedge clk); wr = 0; ev_dn = 0;
    rd_reg(4'h0, d); chk("R5 event wins", d, 32'h001);
    wr_reg(4'h0, 32'h1); rd_reg(4'h0, d); chk("R5 later clear", d, 0);
  endtask

  task automatic t_irq;
    logic [DW-1:0] d;
    wr_reg(4'h8, 32'h004);
    pulse(4'b0001);
    chk("R6 unrouted bit", DW'(irq), 0);
    pulse(4'b0100);
    chk("R6 routed bit", DW'(irq), 1);
    wr_reg(4'h8, 32'h0);
    chk("R6 routing off", DW'(irq), 0);
    rd_reg(4'h0, d); chk("R6 status kept", d, 32'h005);
    wr_reg(4'h8, 32'h001);
    chk("R6 route bit0", DW'(irq), 1);
    wr_reg(4'h0, 32'h1);
    chk("R6 cleared drops irq", DW'(irq), 0);
    wr_reg(4'h0, LIVE); wr_reg(4'h8, 0);
  endtask

  task automatic t_unused;
    logic [DW-1:0] d;
    wr_reg(4'h4, '1); rd_reg(4'h4, d); chk("R7 sten mask", d, LIVE);
    wr_reg(4'h8, '1); rd_reg(4'h8, d); chk("R7 sgen mask", d, LIVE);
    wr_reg(4'hC, '1); rd_reg(4'hC, d); chk("R7 spare addr", d, 0);
    rd_reg(4'h0, d); chk("R7 status unused", d, 0);
    wr_reg(4'h8, 0);
  endtask

  task automatic t_keep;
    logic [DW-1:0] d;
    wr_reg(4'h4, LIVE);
    pulse(4'b0100);
    wr_reg(4'h4, 0);
    rd_reg(4'h0, d); chk("R8 kept after disable", d, 32'h004);
    pulse(4'b1011);
    rd_reg(4'h0, d); chk("R8 no new latch", d, 32'h004);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_latch; t_masked; t_clear; t_race; t_irq; t_unused; t_keep;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule